// File: doc/BRIEF.md
# Audio InfoFrame Packet Builder

This block assembles the audio InfoFrame that a display transmitter sends once per video frame. Five user data bytes arrive as parallel inputs and are captured by a load strobe. The block adds a fixed three-byte header, forces the channel-allocation byte into the form the downstream link expects, fills the unused tail of the payload with zeros and computes the two's-complement checksum in hardware. The finished packet is streamed out one byte per cycle, with valid and last flags, into the packet encoder that follows.

The sender is a two-state machine. In `ST_IDLE` it waits for a frame-start strobe. The transition *launch* to `ST_SEND` happens on a frame start when enable is high and either repeat is on or no packet has gone out since enable last rose. On *launch*, the staged bytes and their checksum are copied into a transmit copy. In `ST_SEND` the byte index counts from 0 to 13, and the transition *finish* returns the machine to `ST_IDLE` after the fourteenth byte. A load strobe only writes the staging registers. A load that arrives while a packet is in flight therefore first shows up in the next packet, and every packet is entirely old or entirely new data.

Byte order on the stream: index 0 type, 1 version, 2 length, 3 checksum, 4 to 8 user bytes 1 to 5, 9 to 13 zero.

Top module: `aud_info_pkt`

## Requirements
- R1: Stream bytes 0, 1 and 2 of every packet are 0x84, 0x01 and 0x0A.
- R2: Stream byte 3 equals (0x100 - S) mod 256, where S is the 8-bit sum of the three header bytes and the five payload bytes as sent, with the channel-allocation byte taken after replacement.
- R3: User bytes 1, 2, 3 and 5 appear unchanged at stream bytes 4, 5, 6 and 8.
- R4: User byte 4, the channel-allocation code, appears at stream byte 7 as 0x13 when it was nonzero at load and as 0x00 when it was zero.
- R5: Stream bytes 9 to 13 are always 0x00.
- R6: A launched packet holds valid high for exactly 14 consecutive cycles, starting in the cycle after the accepted frame-start edge. Last is high only on the 14th byte, and valid is low in the cycle after it.
- R7: With enable and repeat high, every frame start that finds the sender idle launches a packet.
- R8: With repeat low, only one packet is launched after enable rises. Further frame starts send nothing until enable has gone low and high again.
- R9: With enable low, frame starts launch nothing.
- R10: A load during transmission does not alter the packet in flight. The newly loaded bytes appear in the next packet.
- R11: A frame start during transmission is ignored: the packet is neither restarted nor lengthened.
- R12: After reset valid and last are low, and the staged bytes are zero, so a packet sent without a prior load carries zero user bytes and checksum 0x71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usr_b1 | input | 8 | User data byte 1 |
| usr_b2 | input | 8 | User data byte 2 |
| usr_b3 | input | 8 | User data byte 3 |
| usr_b4 | input | 8 | User data byte 4, channel-allocation code |
| usr_b5 | input | 8 | User data byte 5 |
| load_i | input | 1 | Capture the user bytes into staging |
| enable_i | input | 1 | Allow packets to be launched |
| repeat_i | input | 1 | Send on every frame rather than once |
| frame_start_i | input | 1 | One-cycle frame strobe |
| pkt_byte_o | output | 8 | Packet byte stream |
| pkt_valid_o | output | 1 | Stream byte is valid |
| pkt_last_o | output | 1 | Final byte of the packet |

## Verification
The bench targets the channel-allocation code at zero and at nonzero values. A design that forgot the replacement would send the raw code and a checksum that no longer balances, and one that replaced zero as well would send 0x13 where 0x00 belongs. A load in the middle of a packet and a frame start in the middle of a packet are each applied at a fixed byte position. A builder without a separate staging copy would splice old and new bytes together, and one that reacted to the stray frame start would restart the index or stretch valid past 14 cycles. Repeat-off sequences check that a second frame sends nothing and that dropping and raising enable re-arms the sender. Random payloads, including the all-zero reset payload, are compared byte for byte against a checksum the bench computes itself.

// File: rtl/aif_pkg.sv
package aif_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_USER = 5;
    localparam int HDR_LEN  = 4;
    localparam int PAY_LEN  = 10;
    localparam int PKT_LEN  = HDR_LEN + PAY_LEN;
    localparam int IDX_W    = $clog2(PKT_LEN);
    localparam int CA_SLOT  = 3;

    localparam logic [BYTE_W-1:0] HDR_TYPE = 8'h84;
    localparam logic [BYTE_W-1:0] HDR_VER  = 8'h01;
    localparam logic [BYTE_W-1:0] HDR_LEN_B = 8'h0A;
    localparam logic [BYTE_W-1:0] CA_FULL  = 8'h13;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NUM_USER-1:0][BYTE_W-1:0] user_vec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_t;
endpackage

// File: rtl/aif_stage.sv
module aif_stage
    import aif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  user_vec_t user_i,
    output user_vec_t staged_o
);
    user_vec_t cond;

    for (genvar g = 0; g < NUM_USER; g++) begin : g_cond
        if (g == CA_SLOT) begin : g_ca
            assign cond[g] = (user_i[g] != '0) ? CA_FULL : '0;
        end else begin : g_pass
            assign cond[g] = user_i[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_o <= '0;
        end else if (load_i) begin
            staged_o <= cond;
        end
    end

    // R4: the staged channel-allocation code is only ever 0x00 or 0x13
    a_r4_ca_code: assert property (@(posedge clk) disable iff (!rst_n)
        (staged_o[CA_SLOT] == '0) || (staged_o[CA_SLOT] == CA_FULL));
endmodule

// File: rtl/aif_sum.sv
module aif_sum
    import aif_pkg::*;
(
    input  user_vec_t staged_i,
    output byte_t     csum_o
);
    byte_t acc;

    always_comb begin
        acc = HDR_TYPE + HDR_VER + HDR_LEN_B;
        for (int k = 0; k < NUM_USER; k++) begin
            acc = acc + staged_i[k];
        end
        csum_o = byte_t'(9'h100 - {1'b0, acc});
    end
endmodule

// File: rtl/aif_tx.sv
module aif_tx
    import aif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  logic      repeat_i,
    input  logic      frame_start_i,
    input  user_vec_t staged_i,
    input  byte_t     csum_i,
    output byte_t     byte_o,
    output logic      valid_o,
    output logic      last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);
    localparam logic [IDX_W-1:0] TAIL_IDX = IDX_W'(HDR_LEN + NUM_USER);

    tx_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic             sent_q;
    user_vec_t        active_q;
    byte_t            csum_q;
    byte_t            byte_d;
    logic             launch;

    assign launch = (state_q == ST_IDLE) && frame_start_i && enable_i
                    && (repeat_i || !sent_q);

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            active_q <= '0;
            csum_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q  <= ST_SEND;
                        idx_q    <= '0;
                        active_q <= staged_i;
                        csum_q   <= csum_i;
                    end
                end
                ST_SEND: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= 1'b0;
        end else if (!enable_i) begin
            sent_q <= 1'b0;
        end else if (launch) begin
            sent_q <= 1'b1;
        end
    end

    always_comb begin
        byte_d = '0;
        if (idx_q == IDX_W'(0)) begin
            byte_d = HDR_TYPE;
        end else if (idx_q == IDX_W'(1)) begin
            byte_d = HDR_VER;
        end else if (idx_q == IDX_W'(2)) begin
            byte_d = HDR_LEN_B;
        end else if (idx_q == IDX_W'(3)) begin
            byte_d = csum_q;
        end
        for (int k = 0; k < NUM_USER; k++) begin
            if (idx_q == IDX_W'(HDR_LEN + k)) begin
                byte_d = active_q[k];
            end
        end
    end

    // output process
    always_comb begin
        valid_o = (state_q == ST_SEND);
        last_o  = (state_q == ST_SEND) && (idx_q == LAST_IDX);
        byte_o  = valid_o ? byte_d : '0;
    end

    // R6: last only inside a packet, valid unbroken until last
    a_r6_last_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);
    a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);
    a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);
    // R11: a packet in flight only steps forward
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> (idx_q == $past(idx_q) + 1'b1));
    // R10: the transmit copy is frozen while a packet is in flight
    a_r10_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> ($stable(active_q) && $stable(csum_q)));
    // R1: every packet opens with the type byte
    a_r1_type_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (byte_o == HDR_TYPE));
    // R5: zero tail
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (idx_q >= TAIL_IDX)) |-> (byte_o == '0));
    // R9: disabled sender stays silent
    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !enable_i) |=> !valid_o);
endmodule

// File: rtl/aud_info_pkt.sv
module aud_info_pkt
    import aif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] usr_b1,
    input  logic [7:0] usr_b2,
    input  logic [7:0] usr_b3,
    input  logic [7:0] usr_b4,
    input  logic [7:0] usr_b5,
    input  logic       load_i,
    input  logic       enable_i,
    input  logic       repeat_i,
    input  logic       frame_start_i,
    output logic [7:0] pkt_byte_o,
    output logic       pkt_valid_o,
    output logic       pkt_last_o
);
    user_vec_t user_in;
    user_vec_t staged;
    byte_t     csum;

    assign user_in = {usr_b5, usr_b4, usr_b3, usr_b2, usr_b1};

    aif_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .user_i   (user_in),
        .staged_o (staged)
    );

    aif_sum u_sum (
        .staged_i (staged),
        .csum_o   (csum)
    );

    aif_tx u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (enable_i),
        .repeat_i      (repeat_i),
        .frame_start_i (frame_start_i),
        .staged_i      (staged),
        .csum_i        (csum),
        .byte_o        (pkt_byte_o),
        .valid_o       (pkt_valid_o),
        .last_o        (pkt_last_o)
    );
endmodule

// File: tb/sim_aud_info_pkt.sv
`timescale 1ns/1ps
module sim_aud_info_pkt;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] b1 = '0, b2 = '0, b3 = '0, b4 = '0, b5 = '0;
    logic       load = 1'b0, en = 1'b0, rpt = 1'b0, fs = 1'b0;
    logic [7:0] pbyte;
    logic       pvalid, plast;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    aud_info_pkt u0 (
        .clk(clk), .rst_n(rst_n),
        .usr_b1(b1), .usr_b2(b2), .usr_b3(b3), .usr_b4(b4), .usr_b5(b5),
        .load_i(load), .enable_i(en), .repeat_i(rpt), .frame_start_i(fs),
        .pkt_byte_o(pbyte), .pkt_valid_o(pvalid), .pkt_last_o(plast)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles exp completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input int i, input logic [7:0] a, c,
                                            input logic [7:0] d, e, f);
        logic [7:0] ca;
        logic [7:0] s;
        ca = (e != 8'h00) ? 8'h13 : 8'h00;
        s  = 8'h84 + 8'h01 + 8'h0A + a + c + d + ca + f;
        case (i)
            0: return 8'h84;
            1: return 8'h01;
            2: return 8'h0A;
            3: return 8'h00 - s;
            4: return a;
            5: return c;
            6: return d;
            7: return ca;
            8: return f;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        if (i < 3) return "R1";
        if (i == 3) return "R2";
        if (i == 7) return "R4";
        if (i < 9) return "R3";
        return "R5";
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string ctx);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s (%s): got %02h exp %02h", req, ctx, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] a, c, d, e, f);
        @(negedge clk);
        b1 = a; b2 = c; b3 = d; b4 = e; b5 = f;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // act: 0 plain, 1 load mid-packet, 2 frame start mid-packet
    task automatic frame_expect(input logic [7:0] a, c, d, e, f,
                                input int act, input string ctx);
        @(negedge clk);
        fs = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            fs = 1'b0;
            load = 1'b0;
            chk({7'd0, pvalid}, 8'd1, "R6", ctx);
            chk(pbyte, exp_byte(i, a, c, d, e, f), tag_of(i), ctx);
            chk({7'd0, plast}, (i == 13) ? 8'd1 : 8'd0, "R6", ctx);
            if (act == 1 && i == 5) load = 1'b1;
            if (act == 2 && i == 7) fs = 1'b1;
        end
        @(negedge clk);
        fs = 1'b0;
        load = 1'b0;
        chk({7'd0, pvalid}, 8'd0, (act == 2) ? "R11" : "R6", ctx);
    endtask

    task automatic no_packet(input string req);
        bit seen;
        seen = 1'b0;
        @(negedge clk);
        fs = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            fs = 1'b0;
            if (pvalid) seen = 1'b1;
        end
        chk({7'd0, seen}, 8'd0, req, "no packet expected");
    endtask

    initial begin
        int unsigned sd;
        logic [7:0] r1, r2, r3, r4, r5;
        sd = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk({7'd0, pvalid}, 8'd0, "R12", "reset valid");
        chk({7'd0, plast}, 8'd0, "R12", "reset last");
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1; rpt = 1'b1;

        // R12: reset payload, checksum 0x71
        frame_expect(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, "R12 reset payload");
        chk(exp_byte(3, 0, 0, 0, 0, 0), 8'h71, "R12", "checksum of zero payload");

        // R4: zero code passes, nonzero replaced
        do_load(8'h01, 8'h02, 8'h03, 8'h00, 8'h05);
        frame_expect(8'h01, 8'h02, 8'h03, 8'h00, 8'h05, 0, "R4 zero code");
        do_load(8'h11, 8'h22, 8'h33, 8'h2A, 8'h55);
        frame_expect(8'h11, 8'h22, 8'h33, 8'h2A, 8'h55, 0, "R4 nonzero code");
        do_load(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF);
        frame_expect(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 0, "R2 wraparound");

        // R7: repeat on sends every frame
        frame_expect(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 0, "R7 repeat frame a");
        frame_expect(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 0, "R7 repeat frame b");

        // R8: repeat off sends once per enable
        @(negedge clk); en = 1'b0; rpt = 1'b0;
        @(negedge clk); en = 1'b1;
        frame_expect(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 0, "R8 single shot");
        no_packet("R8");
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1;
        frame_expect(8'hFF, 8'hFF, 8'hFF, 8'h01, 8'hFF, 0, "R8 re-armed");

        // R9: disabled
        @(negedge clk); en = 1'b0; rpt = 1'b1;
        no_packet("R9");
        @(negedge clk); en = 1'b1;

        // R10: load mid-packet
        do_load(8'h10, 8'h20, 8'h30, 8'h00, 8'h50);
        @(negedge clk);
        b1 = 8'hA1; b2 = 8'hA2; b3 = 8'hA3; b4 = 8'h07; b5 = 8'hA5;
        frame_expect(8'h10, 8'h20, 8'h30, 8'h00, 8'h50, 1, "R10 old packet intact");
        frame_expect(8'hA1, 8'hA2, 8'hA3, 8'h07, 8'hA5, 0, "R10 new data next packet");

        // R11: frame start mid-packet
        frame_expect(8'hA1, 8'hA2, 8'hA3, 8'h07, 8'hA5, 2, "R11 stray frame start");

        // random payloads
        for (int n = 0; n < 40; n++) begin
            r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
            r4 = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
            r5 = 8'($urandom);
            do_load(r1, r2, r3, r4, r5);
            frame_expect(r1, r2, r3, r4, r5, 0, "R3 random payload");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule